// File: doc/BRIEF.md
# Trace Cache Lookup and Match

This block is the lookup side of a small trace cache placed in front of the instruction cache. Each line holds a dynamic run of up to 16 instruction slots spanning up to 3 basic blocks. A line is named by the address where the run starts and by the directions its internal conditional branches took when it was recorded. Each cycle the front end presents a fetch address and its predicted branch directions. The block looks in the set chosen by the address, in both ways, and answers with one of three results. A full hit returns the whole trace. A partial hit returns only the leading blocks whose branch directions agree with the prediction. A miss tells fetch to go to the instruction cache.

Lines are written through a fill port. The port carries the start address, the recorded directions, the number of recorded branches, the trace length, a per-slot block-end marker and the slot contents. The target way comes from a one-bit replacement pointer per set, which flips after every fill. Two traces with the same start address but different paths can therefore sit side by side in one set.

Top module: `trace_cache_hit`

## Requirements
- R1: While reset is active, and after reset until a line is filled, every result is a miss with a valid count of 0.
- R2: A lookup whose address tag matches no valid way of the indexed set (index = address bits [4:2], tag = bits [31:5]) gives status 2'b00 (miss), a valid count of 0 and all slots zero.
- R3: When a valid way's tag matches and each of its first `nbr` stored direction bits equals the predicted bit at the same position, status is 2'b10 (full hit) and the valid count equals the stored trace length.
- R4: Stored direction bits at positions at or above the line's branch count play no part in matching. A line with 0 branches gives a full hit for every prediction.
- R5: When the tag matches but some compared bit disagrees, status is 2'b01 (partial hit). The first disagreeing bit has index j. The valid count is one plus the slot position of the (j+1)-th block-end marker (bit s of the end vector marks slot s as closing a block). Slots at or above the valid count read as zero.
- R6: Two lines with the same start address and different recorded directions may sit in the two ways of one set. Each is returned for the prediction that matches it.
- R7: A full hit in either way wins over a partial hit in the other way. Between two partial hits the longer prefix wins, and the lower way wins a tie.
- R8: A fill writes the way selected by its set's replacement bit, which then flips. A third fill into a set replaces the line written by the first.
- R9: Results appear on the outputs one clock after the lookup request. With no request, the outputs show a miss with count 0. A lookup in the same cycle as a fill to its set sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Lookup request this cycle |
| lookup_addr_i | input | 32 | Fetch address |
| lookup_pred_i | input | 2 | Predicted directions, bit j for branch j (1 = taken) |
| fill_valid_i | input | 1 | Write a line this cycle |
| fill_addr_i | input | 32 | Start address of the trace being written |
| fill_flags_i | input | 2 | Recorded directions of the trace's branches |
| fill_nbr_i | input | 2 | Number of recorded branches (0 to 2) |
| fill_len_i | input | 5 | Trace length in slots (1 to 16) |
| fill_end_i | input | 16 | Block-end marker per slot |
| fill_slots_i | input | 512 | Slot contents, slot s in bits [32s+31:32s] |
| status_o | output | 2 | 00 miss, 01 partial hit, 10 full hit |
| valid_cnt_o | output | 5 | Number of usable slots |
| slots_o | output | 512 | Delivered slots, zero at and beyond the count |

## Verification
Every set is loaded with a trace that has 0, 1 or 2 recorded branches. Each set is then probed with all four prediction values. This separates full hits, partial hits cut at the first or second branch, and predictions that differ only in ignored direction bits. A second trace is then placed in each set with the inverse directions, so the sweep exercises the choice between a full and a partial hit and between two partial prefixes of different length. Foreign tags, eviction after a third and fourth fill, a lookup that coincides with a fill, and idle cycles separate misses from stale or early hits.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    TC_MISS    = 2'b00,
    TC_PARTIAL = 2'b01,
    TC_FULL    = 2'b10
  } tc_status_e;
endpackage

// File: rtl/tc_store.sv
module tc_store #(
  parameter int TAG_W   = 27,
  parameter int IDX_W   = 3,
  parameter int FLG_W   = 2,
  parameter int BR_W    = 2,
  parameter int CNT_W   = 5,
  parameter int N_SLOTS = 16,
  parameter int INSTR_W = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 fill_i,
  input  logic [IDX_W-1:0]                     fill_idx_i,
  input  logic [TAG_W-1:0]                     fill_tag_i,
  input  logic [FLG_W-1:0]                     fill_flags_i,
  input  logic [BR_W-1:0]                      fill_nbr_i,
  input  logic [CNT_W-1:0]                     fill_len_i,
  input  logic [N_SLOTS-1:0]                   fill_end_i,
  input  logic [N_SLOTS*INSTR_W-1:0]           fill_slots_i,
  input  logic [IDX_W-1:0]                     rd_idx_i,
  output logic [1:0]                           rd_valid_o,
  output logic [1:0][TAG_W-1:0]                rd_tag_o,
  output logic [1:0][FLG_W-1:0]                rd_flags_o,
  output logic [1:0][BR_W-1:0]                 rd_nbr_o,
  output logic [1:0][CNT_W-1:0]                rd_len_o,
  output logic [1:0][N_SLOTS-1:0]              rd_end_o,
  output logic [1:0][N_SLOTS*INSTR_W-1:0]      rd_slots_o
);
  localparam int SETS = 1 << IDX_W;
  localparam int WAYS = 2;

  logic [SETS-1:0]           repl_q;
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [WAYS-1:0]           we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      repl_q  <= '0;
      valid_q <= '0;
    end else if (fill_i) begin
      valid_q[fill_idx_i][repl_q[fill_idx_i]] <= 1'b1;
      repl_q[fill_idx_i] <= ~repl_q[fill_idx_i];
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]           tag_q   [SETS];
    logic [FLG_W-1:0]           flags_q [SETS];
    logic [BR_W-1:0]            nbr_q   [SETS];
    logic [CNT_W-1:0]           len_q   [SETS];
    logic [N_SLOTS-1:0]         end_q   [SETS];
    logic [N_SLOTS*INSTR_W-1:0] slots_q [SETS];

    assign we[w] = fill_i && (repl_q[fill_idx_i] == 1'(w));

    always_ff @(posedge clk_i) begin
      if (we[w]) begin
        tag_q[fill_idx_i]   <= fill_tag_i;
        flags_q[fill_idx_i] <= fill_flags_i;
        nbr_q[fill_idx_i]   <= fill_nbr_i;
        len_q[fill_idx_i]   <= fill_len_i;
        end_q[fill_idx_i]   <= fill_end_i;
        slots_q[fill_idx_i] <= fill_slots_i;
      end
    end

    assign rd_tag_o[w]   = tag_q[rd_idx_i];
    assign rd_flags_o[w] = flags_q[rd_idx_i];
    assign rd_nbr_o[w]   = nbr_q[rd_idx_i];
    assign rd_len_o[w]   = len_q[rd_idx_i];
    assign rd_end_o[w]   = end_q[rd_idx_i];
    assign rd_slots_o[w] = slots_q[rd_idx_i];
  end

  // R8: exactly one way written per fill, pointer flips, written way becomes valid
  p_single_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
  p_repl_flip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> repl_q[$past(fill_idx_i)] != $past(repl_q[fill_idx_i]));
  p_fill_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[$past(fill_idx_i)][$past(repl_q[fill_idx_i])]);
endmodule

// File: rtl/tc_way_match.sv
module tc_way_match #(
  parameter int TAG_W   = 27,
  parameter int FLG_W   = 2,
  parameter int BR_W    = 2,
  parameter int CNT_W   = 5,
  parameter int N_SLOTS = 16
) (
  input  logic               valid_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [FLG_W-1:0]   flags_i,
  input  logic [BR_W-1:0]    nbr_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic [N_SLOTS-1:0] end_i,
  input  logic [TAG_W-1:0]   req_tag_i,
  input  logic [FLG_W-1:0]   pred_i,
  output logic               hit_o,
  output logic               full_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [FLG_W-1:0] mism;
  logic [CNT_W-1:0] first_mm;
  logic [CNT_W-1:0] seen;
  logic [CNT_W-1:0] plen;
  logic             found;

  assign hit_o = valid_i && (tag_i == req_tag_i);

  // only branches present in the trace are compared
  always_comb begin
    mism = '0;
    for (int j = 0; j < FLG_W; j++)
      if (j < int'(nbr_i) && (flags_i[j] != pred_i[j])) mism[j] = 1'b1;
  end

  always_comb begin
    first_mm = '0;
    for (int j = FLG_W - 1; j >= 0; j--)
      if (mism[j]) first_mm = CNT_W'(j);
  end

  // prefix ends at the block closed by the first disagreeing branch
  always_comb begin
    seen  = '0;
    plen  = len_i;
    found = 1'b0;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (end_i[s]) begin
        if (!found && seen == first_mm) begin
          plen  = CNT_W'(s + 1);
          found = 1'b1;
        end
        seen = seen + 1'b1;
      end
    end
  end

  assign full_o = hit_o && (mism == '0);

  always_comb begin
    if (!hit_o)      cnt_o = '0;
    else if (full_o) cnt_o = len_i;
    else             cnt_o = (plen > len_i) ? len_i : plen;
  end
endmodule

// File: rtl/tc_select.sv
module tc_select
  import tc_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int CNT_W = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [WAYS-1:0]            hit_i,
  input  logic [WAYS-1:0]            full_i,
  input  logic [WAYS-1:0][CNT_W-1:0] cnt_i,
  output tc_status_e                 status_o,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [WAYS-1:0]            sel_o
);
  logic found_full;

  always_comb begin
    sel_o      = '0;
    status_o   = TC_MISS;
    cnt_o      = '0;
    found_full = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (full_i[w] && !found_full) begin
        found_full = 1'b1;
        sel_o      = '0;
        sel_o[w]   = 1'b1;
        cnt_o      = cnt_i[w];
        status_o   = TC_FULL;
      end
    end
    if (!found_full) begin
      for (int w = 0; w < WAYS; w++) begin
        if (hit_i[w] && (status_o == TC_MISS || cnt_i[w] > cnt_o)) begin
          sel_o    = '0;
          sel_o[w] = 1'b1;
          cnt_o    = cnt_i[w];
          status_o = TC_PARTIAL;
        end
      end
    end
  end

  // R7: at most one way delivers; a full hit always wins
  p_sel_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_full_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|full_i) |-> (status_o == TC_FULL));
endmodule

// File: rtl/trace_cache_hit.sv
module trace_cache_hit
  import tc_pkg::*;
#(
  parameter int  ADDR_W   = 32,
  parameter int  INSTR_W  = 32,
  parameter int  N_SLOTS  = 16,
  parameter int  M_BLOCKS = 3,
  parameter int  IDX_W    = 3,
  localparam int FLG_W    = M_BLOCKS - 1,
  localparam int BR_W     = $clog2(M_BLOCKS),
  localparam int CNT_W    = $clog2(N_SLOTS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         lookup_valid_i,
  input  logic [ADDR_W-1:0]            lookup_addr_i,
  input  logic [FLG_W-1:0]             lookup_pred_i,
  input  logic                         fill_valid_i,
  input  logic [ADDR_W-1:0]            fill_addr_i,
  input  logic [FLG_W-1:0]             fill_flags_i,
  input  logic [BR_W-1:0]              fill_nbr_i,
  input  logic [CNT_W-1:0]             fill_len_i,
  input  logic [N_SLOTS-1:0]           fill_end_i,
  input  logic [N_SLOTS*INSTR_W-1:0]   fill_slots_i,
  output logic [1:0]                   status_o,
  output logic [CNT_W-1:0]             valid_cnt_o,
  output logic [N_SLOTS*INSTR_W-1:0]   slots_o
);
  localparam int WAYS  = 2;
  localparam int OFF_W = 2;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag;

  assign lk_idx = lookup_addr_i[OFF_W +: IDX_W];
  assign lk_tag = lookup_addr_i[ADDR_W-1 -: TAG_W];
  assign fl_idx = fill_addr_i[OFF_W +: IDX_W];
  assign fl_tag = fill_addr_i[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]                      rd_valid;
  logic [WAYS-1:0][TAG_W-1:0]           rd_tag;
  logic [WAYS-1:0][FLG_W-1:0]           rd_flags;
  logic [WAYS-1:0][BR_W-1:0]            rd_nbr;
  logic [WAYS-1:0][CNT_W-1:0]           rd_len;
  logic [WAYS-1:0][N_SLOTS-1:0]         rd_end;
  logic [WAYS-1:0][N_SLOTS*INSTR_W-1:0] rd_slots;

  tc_store #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .FLG_W(FLG_W), .BR_W(BR_W),
    .CNT_W(CNT_W), .N_SLOTS(N_SLOTS), .INSTR_W(INSTR_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_i       (fill_valid_i),
    .fill_idx_i   (fl_idx),
    .fill_tag_i   (fl_tag),
    .fill_flags_i (fill_flags_i),
    .fill_nbr_i   (fill_nbr_i),
    .fill_len_i   (fill_len_i),
    .fill_end_i   (fill_end_i),
    .fill_slots_i (fill_slots_i),
    .rd_idx_i     (lk_idx),
    .rd_valid_o   (rd_valid),
    .rd_tag_o     (rd_tag),
    .rd_flags_o   (rd_flags),
    .rd_nbr_o     (rd_nbr),
    .rd_len_o     (rd_len),
    .rd_end_o     (rd_end),
    .rd_slots_o   (rd_slots)
  );

  logic [WAYS-1:0]            way_hit, way_full;
  logic [WAYS-1:0][CNT_W-1:0] way_cnt;

  for (genvar w = 0; w < WAYS; w++) begin : g_match
    tc_way_match #(
      .TAG_W(TAG_W), .FLG_W(FLG_W), .BR_W(BR_W),
      .CNT_W(CNT_W), .N_SLOTS(N_SLOTS)
    ) u_match (
      .valid_i   (rd_valid[w]),
      .tag_i     (rd_tag[w]),
      .flags_i   (rd_flags[w]),
      .nbr_i     (rd_nbr[w]),
      .len_i     (rd_len[w]),
      .end_i     (rd_end[w]),
      .req_tag_i (lk_tag),
      .pred_i    (lookup_pred_i),
      .hit_o     (way_hit[w]),
      .full_o    (way_full[w]),
      .cnt_o     (way_cnt[w])
    );
  end

  tc_status_e       sel_status;
  logic [CNT_W-1:0] sel_cnt;
  logic [WAYS-1:0]  sel_way;

  tc_select #(.WAYS(WAYS), .CNT_W(CNT_W)) u_select (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (way_hit),
    .full_i   (way_full),
    .cnt_i    (way_cnt),
    .status_o (sel_status),
    .cnt_o    (sel_cnt),
    .sel_o    (sel_way)
  );

  logic [N_SLOTS*INSTR_W-1:0] slots_d;

  always_comb begin
    slots_d = '0;
    for (int w = 0; w < WAYS; w++)
      if (sel_way[w]) slots_d = rd_slots[w];
    for (int s = 0; s < N_SLOTS; s++)
      if (CNT_W'(s) >= sel_cnt) slots_d[s*INSTR_W +: INSTR_W] = '0;
  end

  tc_status_e                 status_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [N_SLOTS*INSTR_W-1:0] slots_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= TC_MISS;
      cnt_q    <= '0;
      slots_q  <= '0;
    end else if (lookup_valid_i) begin
      status_q <= sel_status;
      cnt_q    <= sel_cnt;
      slots_q  <= slots_d;
    end else begin
      status_q <= TC_MISS;
      cnt_q    <= '0;
      slots_q  <= '0;
    end
  end

  assign status_o    = status_q;
  assign valid_cnt_o = cnt_q;
  assign slots_o     = slots_q;

  p_miss_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == TC_MISS) |-> (valid_cnt_o == '0));
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_cnt_o <= CNT_W'(N_SLOTS));
  p_partial_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == TC_PARTIAL) |-> (valid_cnt_o != '0));
  p_idle_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (status_o == TC_MISS));
  p_status_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b11);
endmodule

// File: tb/trace_cache_hit_bench.sv
module trace_cache_hit_bench;
  localparam int CLK_P = 10;
  localparam int NS    = 16;
  localparam int IW    = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            lookup_valid_i = 1'b0;
  logic [31:0]     lookup_addr_i = '0;
  logic [1:0]      lookup_pred_i = '0;
  logic            fill_valid_i = 1'b0;
  logic [31:0]     fill_addr_i = '0;
  logic [1:0]      fill_flags_i = '0;
  logic [1:0]      fill_nbr_i = '0;
  logic [4:0]      fill_len_i = '0;
  logic [NS-1:0]   fill_end_i = '0;
  logic [NS*IW-1:0] fill_slots_i = '0;
  logic [1:0]      status_o;
  logic [4:0]      valid_cnt_o;
  logic [NS*IW-1:0] slots_o;

  always #(CLK_P/2) clk = ~clk;

  trace_cache_hit u_trace_cache_hit (
    .clk_i(clk), .rst_ni(rst_ni),
    .lookup_valid_i(lookup_valid_i), .lookup_addr_i(lookup_addr_i),
    .lookup_pred_i(lookup_pred_i),
    .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i),
    .fill_flags_i(fill_flags_i), .fill_nbr_i(fill_nbr_i),
    .fill_len_i(fill_len_i), .fill_end_i(fill_end_i),
    .fill_slots_i(fill_slots_i),
    .status_o(status_o), .valid_cnt_o(valid_cnt_o), .slots_o(slots_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench-side model of the line contents
  bit          m_v     [8][2];
  logic [26:0] m_tag   [8][2];
  logic [1:0]  m_flags [8][2];
  int          m_nbr   [8][2];
  int          m_len   [8][2];
  int          m_p0    [8][2];
  int          m_p1    [8][2];
  logic [31:0] m_base  [8][2];
  bit          m_repl  [8];

  function automatic logic [31:0] mk_addr(input logic [26:0] tag, input int idx);
    return {tag, 3'(idx), 2'b00};
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_calc(input logic [26:0] tag, input int idx, input logic [1:0] pred,
                            output int st, output int cnt, output logic [31:0] base);
    int pc [2];
    int ps;
    bit pf;
    st = 0; cnt = 0; base = '0;
    pf = 1'b0; ps = 0;
    for (int w = 0; w < 2; w++) begin
      int j;
      pc[w] = -1;
      if (m_v[idx][w] && m_tag[idx][w] == tag) begin
        j = -1;
        for (int b = m_nbr[idx][w] - 1; b >= 0; b--)
          if (m_flags[idx][w][b] != pred[b]) j = b;
        if (j < 0) pc[w] = 100 + m_len[idx][w];
        else pc[w] = (j == 0) ? m_p0[idx][w] + 1 : m_p1[idx][w] + 1;
      end
    end
    for (int w = 0; w < 2; w++) begin
      if (pc[w] >= 100 && st != 2) begin
        st = 2; cnt = pc[w] - 100; base = m_base[idx][w];
      end
    end
    if (st != 2) begin
      for (int w = 0; w < 2; w++) begin
        if (pc[w] > 0 && (st == 0 || pc[w] > cnt)) begin
          st = 1; cnt = pc[w]; base = m_base[idx][w];
        end
      end
    end
  endtask

  task automatic check_out(input string req, input int st, input int cnt, input logic [31:0] base);
    bit bad;
    int first_bad;
    logic [31:0] exp_s;
    check_int(req, "status", int'(status_o), st);
    check_int(req, "count", int'(valid_cnt_o), cnt);
    bad = 1'b0; first_bad = 0;
    for (int s = NS - 1; s >= 0; s--) begin
      exp_s = (s < cnt) ? base + 32'(s) : 32'h0;
      if (slots_o[s*IW +: IW] !== exp_s) begin bad = 1'b1; first_bad = s; end
    end
    checks++;
    if (bad) begin
      failures++;
      exp_s = (first_bad < cnt) ? base + 32'(first_bad) : 32'h0;
      $display("FAIL %s slot %0d: actual=%h expected=%h", req, first_bad,
               slots_o[first_bad*IW +: IW], exp_s);
    end
  endtask

  task automatic drive_fill(input logic [26:0] tag, input int idx, input logic [1:0] flags,
                            input int nbr, input int p0, input int p1, input int len,
                            input logic [31:0] base);
    logic [NS-1:0] ev;
    ev = '0;
    if (nbr >= 1) ev[p0] = 1'b1;
    if (nbr >= 2) ev[p1] = 1'b1;
    ev[len-1] = 1'b1;
    fill_valid_i = 1'b1;
    fill_addr_i  = mk_addr(tag, idx);
    fill_flags_i = flags;
    fill_nbr_i   = 2'(nbr);
    fill_len_i   = 5'(len);
    fill_end_i   = ev;
    for (int s = 0; s < NS; s++)
      fill_slots_i[s*IW +: IW] = (s < len) ? base + 32'(s) : (32'hDEAD0000 | 32'(s));
  endtask

  task automatic model_fill(input logic [26:0] tag, input int idx, input logic [1:0] flags,
                            input int nbr, input int p0, input int p1, input int len,
                            input logic [31:0] base);
    int w;
    w = int'(m_repl[idx]);
    m_v[idx][w] = 1'b1; m_tag[idx][w] = tag; m_flags[idx][w] = flags;
    m_nbr[idx][w] = nbr; m_p0[idx][w] = p0; m_p1[idx][w] = p1;
    m_len[idx][w] = len; m_base[idx][w] = base;
    m_repl[idx] = ~m_repl[idx];
  endtask

  task automatic do_fill(input logic [26:0] tag, input int idx, input logic [1:0] flags,
                         input int nbr, input int p0, input int p1, input int len,
                         input logic [31:0] base);
    @(negedge clk);
    drive_fill(tag, idx, flags, nbr, p0, p1, len, base);
    @(negedge clk);
    fill_valid_i = 1'b0;
    model_fill(tag, idx, flags, nbr, p0, p1, len, base);
  endtask

  task automatic do_lookup(input string req, input logic [26:0] tag, input int idx,
                           input logic [1:0] pred);
    int st, cnt;
    logic [31:0] base;
    model_calc(tag, idx, pred, st, cnt, base);
    @(negedge clk);
    lookup_valid_i = 1'b1;
    lookup_addr_i  = mk_addr(tag, idx);
    lookup_pred_i  = pred;
    @(negedge clk);
    lookup_valid_i = 1'b0;
    check_out(req, st, cnt, base);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_repl[i] = 1'b0;
      for (int w = 0; w < 2; w++) m_v[i][w] = 1'b0;
    end
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    check_int("R1", "status in reset", int'(status_o), 0);
    check_int("R1", "count in reset", int'(valid_cnt_o), 0);
    rst_ni = 1'b1;
    // R1: empty cache misses everywhere
    for (int i = 0; i < 8; i++) do_lookup("R1", 27'd5, i, 2'(i));

    // R3 R4 R5: one trace per set, 0..2 branches, all predictions
    for (int i = 0; i < 8; i++)
      do_fill(27'(100 + i), i, 2'(i), i % 3, 1 + i, 3 + i + i % 3, 16 - i % 4,
              32'(i) << 8);
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 4; p++) do_lookup("R3 R4 R5", 27'(100 + i), i, 2'(p));

    // R2: foreign tags
    for (int i = 0; i < 8; i++) do_lookup("R2", 27'd999, i, 2'(i));
    do_lookup("R2", 27'(101), 0, 2'd0);

    // R6 R7: second path with inverted directions in way 1
    for (int i = 0; i < 8; i++)
      do_fill(27'(100 + i), i, ~2'(i), 2, 2, 5 + i % 4, 12,
              32'h0001_0000 | (32'(i) << 8));
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 4; p++) do_lookup("R6 R7", 27'(100 + i), i, 2'(p));

    // R7: two partials of different length (way0 flags 00 ends 2/6, way1 flags 11 ends 4/9)
    do_fill(27'd200, 4, 2'b00, 2, 2, 6, 12, 32'h0002_0000);
    do_fill(27'd200, 4, 2'b11, 2, 4, 9, 14, 32'h0003_0000);
    do_lookup("R7", 27'd200, 4, 2'b01);
    do_lookup("R7", 27'd200, 4, 2'b10);

    // R8: third fill replaces the first, fourth the second
    do_fill(27'd300, 3, 2'b01, 1, 4, 0, 9, 32'h0004_0000);
    for (int p = 0; p < 4; p++) do_lookup("R8", 27'(103), 3, 2'(p));
    do_lookup("R8", 27'd300, 3, 2'b11);
    do_fill(27'd301, 3, 2'b00, 0, 0, 0, 7, 32'h0005_0000);
    for (int p = 0; p < 4; p++) do_lookup("R8", 27'(103), 3, 2'(p));
    do_lookup("R8", 27'd301, 3, 2'b10);
    do_lookup("R8", 27'd300, 3, 2'b11);

    // R9: lookup alongside a fill to the same set sees old contents
    @(negedge clk);
    drive_fill(27'd400, 5, 2'b10, 2, 3, 7, 11, 32'h0006_0000);
    lookup_valid_i = 1'b1;
    lookup_addr_i  = mk_addr(27'd400, 5);
    lookup_pred_i  = 2'b10;
    @(negedge clk);
    fill_valid_i   = 1'b0;
    lookup_valid_i = 1'b0;
    check_out("R9", 0, 0, 32'h0);
    model_fill(27'd400, 5, 2'b10, 2, 3, 7, 11, 32'h0006_0000);
    do_lookup("R9", 27'd400, 5, 2'b10);
    // R9: idle cycle shows a miss
    @(negedge clk);
    check_out("R9", 0, 0, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule